// File: doc/BRIEF.md
# Parity-Checked SPI Register Slave

This block is a 16-bit SPI slave that gives a host controller access to a small bank of 4-bit registers. Each frame, sent MSB first, is made of a 6-bit address, two copies of the read/write code, four parity bits and four data bits. Every SPI input is brought into the system clock domain through a synchronizer. Edges of the serial clock and chip select are then detected in that domain, so the core logic is fully synchronous.

The block answers each frame in two parts. In the first eight clocks it shifts out the address and read/write bits of the last well-formed frame. When the eighth bit has arrived, it fetches the newly addressed register and sends the parity and data of that register during the last eight clocks. A write takes effect only on the rising edge of chip select. It needs a frame of exactly sixteen clocks, two matching write codes and correct parity. Any malformed frame sets a sticky error flag.

A mode register and a validation register guard the mode output. The output takes the mode value only while both registers hold the same value, so a single stray write cannot change the mode.

Top module: `spi_parity_regs`

## Requirements
- R1: A frame is 16 bits sent MSB first in the order address[5:0], rw[1:0], parity[3:0], data[3:0]. MOSI is sampled on the falling edge of SCLK, and MISO changes on the rising edge of SCLK.
- R2: The expected parity for data d is {d3^d0, d3^d2, d2^d1, d1^d0}. If the received parity differs, the frame is discarded and the error flag is set. This applies to read frames as well as write frames.
- R3: A frame with rw=2'b11 writes its data into the addressed register at the rising edge of chip select, and only when the frame is valid. A frame with rw=2'b00 writes nothing.
- R4: A frame whose two rw bits differ sets the error flag and writes nothing.
- R5: A frame that does not have exactly 16 falling SCLK edges before chip select rises sets the error flag and writes nothing.
- R6: The first 8 bits on MISO are the address and rw bits of the most recent frame that had exactly 16 clocks. After reset they are zero.
- R7: The last 8 bits on MISO are {parity, data} of the register addressed by the current frame. The mode register is at address 6'h03, the validation register at 6'h0C and the status register at 6'h30. Any other address reads as 8'h00.
- R8: mode_out takes the mode register value only while the mode register equals the validation register. Otherwise mode_out holds its value. All of these are zero after reset.
- R9: The error flag is sticky. A valid write of 4'hA to the status address clears it. The status register reads the flag in data bit 0.
- R10: miso_oe is high only while chip select is low. SCLK and MOSI activity while chip select is high changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| mode_out | output | 4 | Mode value, updated only after validation |
| err_flag | output | 1 | Sticky frame error flag |

## Verification
The hardest behaviour to reach is the two-part reply. The header echo depends on the frame before, and the read data is chosen by bits that arrive halfway through the current frame. The bench therefore runs chains of back-to-back frames and checks every reply against a header it records itself. Malformed frames are placed between good ones (frames that are too short or too long, bad parity, split rw codes, and clock toggling with chip select high). The bench then shows that the echo still reports the last 16-clock frame and that none of the registers moved.

// File: rtl/spi_prt_pkg.sv
package spi_prt_pkg;
  localparam int DW = 4;
  localparam int AW = 6;
  localparam int FW = AW + 2 + 2 * DW;
  localparam int HW = AW + 2;
  localparam int CW = $clog2(FW + 2);
  localparam logic [1:0] RW_WR = 2'b11;

  // Pairwise XOR check nibble over the data nibble
  function automatic logic [DW-1:0] nib_parity(input logic [DW-1:0] d);
    return {d[3] ^ d[0], d[3] ^ d[2], d[2] ^ d[1], d[1] ^ d[0]};
  endfunction
endpackage

// File: rtl/spi_prt_sync.sv
module spi_prt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST_VAL;
        else if (i == 0) pipe[i] <= d;
        else pipe[i] <= pipe[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_prt_shifter.sv
module spi_prt_shifter
  import spi_prt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_start,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic [HW-1:0] hdr_prev,
  input  logic [HW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic [FW-1:0] rx_word,
  output logic [CW-1:0] bit_cnt,
  output logic          miso_bit
);
  localparam logic [CW-1:0] CNT_SAT = CW'(FW + 1);
  localparam logic [CW-1:0] CNT_HDR = CW'(HW);

  logic [FW-1:0] tx_word;
  logic          rd_loaded;
  logic          load_evt;

  assign load_evt = (bit_cnt == CNT_HDR) && !rd_loaded;
  assign rd_addr  = rx_word[HW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word   <= '0;
      tx_word   <= '0;
      bit_cnt   <= '0;
      rd_loaded <= 1'b0;
      miso_bit  <= 1'b0;
    end else if (cs_start) begin
      tx_word   <= {hdr_prev, {(FW-HW){1'b0}}};
      bit_cnt   <= '0;
      rd_loaded <= 1'b0;
      miso_bit  <= 1'b0;
    end else begin
      if (sclk_fall) begin
        rx_word <= {rx_word[FW-2:0], mosi_s};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_rise) begin
        miso_bit <= tx_word[FW-1];
        tx_word  <= {tx_word[FW-2:0], 1'b0};
      end else if (load_evt) begin
        tx_word[FW-1:FW-HW] <= rd_word;
        rd_loaded <= 1'b1;
      end
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT); // R5
  AST_HDR_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_loaded && !cs_start |=> rd_loaded); // R7
endmodule

// File: rtl/spi_prt_regbank.sv
module spi_prt_regbank
  import spi_prt_pkg::*;
#(
  parameter logic [AW-1:0] ADDR_MODE = 6'h03,
  parameter logic [AW-1:0] ADDR_VALID = 6'h0C,
  parameter logic [AW-1:0] ADDR_STAT = 6'h30,
  parameter logic [DW-1:0] CLR_CODE = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_end,
  input  logic [FW-1:0] rx_word,
  input  logic [CW-1:0] bit_cnt,
  input  logic [AW-1:0] rd_addr,
  output logic [HW-1:0] rd_word,
  output logic [HW-1:0] hdr_prev,
  output logic [DW-1:0] mode_out,
  output logic          err_flag
);
  logic [AW-1:0] f_addr;
  logic [1:0]    f_rw;
  logic [DW-1:0] f_par, f_data, rd_data;
  logic [DW-1:0] mode_reg, valid_reg;
  logic          len_ok, rw_ok, par_ok, frame_ok, wr_evt, clr_evt, bad_evt;

  assign {f_addr, f_rw, f_par, f_data} = rx_word;
  assign len_ok   = (bit_cnt == CW'(FW));
  assign rw_ok    = (f_rw[1] == f_rw[0]);
  assign par_ok   = (f_par == nib_parity(f_data));
  assign frame_ok = len_ok && rw_ok && par_ok;
  assign wr_evt   = cs_end && frame_ok && (f_rw == RW_WR);
  assign clr_evt  = wr_evt && (f_addr == ADDR_STAT) && (f_data == CLR_CODE);
  assign bad_evt  = cs_end && !frame_ok;

  always_comb begin
    case (rd_addr)
      ADDR_MODE:  rd_data = mode_reg;
      ADDR_VALID: rd_data = valid_reg;
      ADDR_STAT:  rd_data = {{(DW-1){1'b0}}, err_flag};
      default:    rd_data = '0;
    endcase
    rd_word = {nib_parity(rd_data), rd_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_reg  <= '0;
      valid_reg <= '0;
      mode_out  <= '0;
      err_flag  <= 1'b0;
      hdr_prev  <= '0;
    end else begin
      if (wr_evt && f_addr == ADDR_MODE)  mode_reg  <= f_data;
      if (wr_evt && f_addr == ADDR_VALID) valid_reg <= f_data;
      if (mode_reg == valid_reg) mode_out <= mode_reg;
      if (bad_evt) err_flag <= 1'b1;
      else if (clr_evt) err_flag <= 1'b0;
      if (cs_end && len_ok) hdr_prev <= {f_addr, f_rw};
    end
  end

  AST_BAD_FRAME_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> $stable(mode_reg) && $stable(valid_reg)); // R3
  AST_BAD_FRAME_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> err_flag); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_evt |=> err_flag); // R9
  AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_out) |-> $past(mode_reg == valid_reg) && mode_out == $past(mode_reg)); // R8
endmodule

// File: rtl/spi_parity_regs.sv
module spi_parity_regs
  import spi_prt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] ADDR_MODE = 6'h03,
  parameter logic [AW-1:0] ADDR_VALID = 6'h0C,
  parameter logic [AW-1:0] ADDR_STAT = 6'h30,
  parameter logic [DW-1:0] CLR_CODE = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_csn,
  input  logic          spi_sclk,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          miso_oe,
  output logic [DW-1:0] mode_out,
  output logic          err_flag
);
  logic          csn_s, sclk_s, mosi_s, csn_d, sclk_d;
  logic          cs_start, cs_end, sclk_rise, sclk_fall;
  logic [HW-1:0] hdr_prev, rd_word;
  logic [AW-1:0] rd_addr;
  logic [FW-1:0] rx_word;
  logic [CW-1:0] bit_cnt;

  spi_prt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sclk, spi_mosi}),
    .q({csn_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= csn_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_start  = csn_d && !csn_s;
  assign cs_end    = !csn_d && csn_s;
  assign sclk_rise = !csn_s && sclk_s && !sclk_d;
  assign sclk_fall = !csn_s && !sclk_s && sclk_d;
  assign miso_oe   = !csn_s;

  spi_prt_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .hdr_prev(hdr_prev),
    .rd_word(rd_word), .rd_addr(rd_addr), .rx_word(rx_word),
    .bit_cnt(bit_cnt), .miso_bit(spi_miso)
  );

  spi_prt_regbank #(
    .ADDR_MODE(ADDR_MODE), .ADDR_VALID(ADDR_VALID),
    .ADDR_STAT(ADDR_STAT), .CLR_CODE(CLR_CODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .rx_word(rx_word),
    .bit_cnt(bit_cnt), .rd_addr(rd_addr), .rd_word(rd_word),
    .hdr_prev(hdr_prev), .mode_out(mode_out), .err_flag(err_flag)
  );

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s && !cs_end |=> $stable(bit_cnt) && $stable(rx_word)); // R10
endmodule

// File: tb/spi_parity_regs_test.sv
module spi_parity_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, oe, err;
  logic [3:0] mode;
  int checks = 0, errors = 0;
  logic [15:0] rxw;

  always #5 clk = ~clk;

  spi_parity_regs uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .miso_oe(oe), .mode_out(mode), .err_flag(err)
  );

  function automatic logic [3:0] par(input logic [3:0] d);
    logic [3:0] p;
    p[0] = d[0] ^ d[1];
    p[1] = d[1] ^ d[2];
    p[2] = d[2] ^ d[3];
    p[3] = d[0] ^ d[3];
    return p;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits falling edges; bits beyond 16 are zero; MISO captured before each fall
  task automatic frame(input logic [5:0] a, input logic [1:0] rw, input logic [3:0] d,
                       input bit bad_par, input int nbits, output logic [15:0] rx);
    logic [15:0] w;
    logic [3:0] p;
    p = par(d) ^ (bad_par ? 4'b0100 : 4'b0000);
    w = {a, rw, p, d};
    rx = '0;
    csn = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15 - i] : 1'b0;
      sclk = 1'b1;
      wait_clk(8);
      if (i < 16) rx[15 - i] = miso;
      if (i == 0) chk("R10 oe in frame", {15'd0, oe}, 16'd1);
      sclk = 1'b0;
      wait_clk(8);
    end
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic t_reset;
    chk("R8 reset mode", {12'd0, mode}, 16'd0);
    chk("R9 reset err", {15'd0, err}, 16'd0);
    chk("R10 reset oe", {15'd0, oe}, 16'd0);
  endtask

  task automatic t_write_read;
    logic [15:0] r;
    frame(6'h03, 2'b11, 4'h5, 0, 16, r);
    chk("R6 echo after reset", {8'd0, r[15:8]}, 16'h0000);
    chk("R8 mode held unvalidated", {12'd0, mode}, 16'd0);
    frame(6'h03, 2'b00, 4'h0, 0, 16, r);
    chk("R6 echo write header", {8'd0, r[15:8]}, {8'd0, 6'h03, 2'b11});
    chk("R7 R3 read mode reg", {8'd0, r[7:0]}, {8'd0, par(4'h5), 4'h5});
    frame(6'h0C, 2'b11, 4'h5, 0, 16, r);
    chk("R8 mode taken when equal", {12'd0, mode}, 16'h5);
    frame(6'h03, 2'b11, 4'h6, 0, 16, r);
    chk("R8 mode held on mismatch", {12'd0, mode}, 16'h5);
    frame(6'h21, 2'b00, 4'h0, 0, 16, r);
    chk("R7 unknown addr reads 0", {8'd0, r[7:0]}, 16'h0000);
    chk("R1 R6 echo mode write", {8'd0, r[15:8]}, {8'd0, 6'h03, 2'b11});
    chk("R2 good frames no err", {15'd0, err}, 16'd0);
  endtask

  task automatic t_parity;
    logic [15:0] r;
    frame(6'h0C, 2'b11, 4'h9, 1, 16, r);
    chk("R2 bad parity sets err", {15'd0, err}, 16'd1);
    frame(6'h0C, 2'b00, 4'h0, 0, 16, r);
    chk("R2 bad parity no write", {8'd0, r[7:0]}, {8'd0, par(4'h5), 4'h5});
    frame(6'h30, 2'b00, 4'h0, 0, 16, r);
    chk("R9 status reads err", {8'd0, r[7:0]}, {8'd0, par(4'h1), 4'h1});
    frame(6'h30, 2'b11, 4'h3, 0, 16, r);
    chk("R9 wrong code keeps err", {15'd0, err}, 16'd1);
    frame(6'h30, 2'b11, 4'hA, 0, 16, r);
    chk("R9 clear code clears", {15'd0, err}, 16'd0);
    frame(6'h21, 2'b00, 4'h2, 1, 16, r);
    chk("R2 bad parity on read sets err", {15'd0, err}, 16'd1);
    frame(6'h30, 2'b11, 4'hA, 0, 16, r);
  endtask

  task automatic t_rw_split;
    logic [15:0] r;
    frame(6'h0C, 2'b10, 4'h7, 0, 16, r);
    chk("R4 split rw sets err", {15'd0, err}, 16'd1);
    frame(6'h0C, 2'b00, 4'h0, 0, 16, r);
    chk("R4 split rw no write", {8'd0, r[7:0]}, {8'd0, par(4'h5), 4'h5});
    chk("R8 mode unchanged", {12'd0, mode}, 16'h5);
    frame(6'h30, 2'b11, 4'hA, 0, 16, r);
  endtask

  task automatic t_length;
    logic [15:0] r;
    frame(6'h0C, 2'b11, 4'h3, 0, 12, r);
    chk("R5 short frame err", {15'd0, err}, 16'd1);
    frame(6'h0C, 2'b11, 4'h3, 0, 17, r);
    chk("R6 echo skips short frame", {8'd0, r[15:8]}, {8'd0, 6'h30, 2'b11});
    frame(6'h0C, 2'b00, 4'h0, 0, 16, r);
    chk("R5 bad length no write", {8'd0, r[7:0]}, {8'd0, par(4'h5), 4'h5});
    chk("R6 echo skips long frame", {8'd0, r[15:8]}, {8'd0, 6'h30, 2'b11});
    frame(6'h30, 2'b11, 4'hA, 0, 16, r);
  endtask

  task automatic t_idle;
    logic [15:0] r;
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk;
      mosi = i[1];
      wait_clk(6);
      chk("R10 oe low while idle", {15'd0, oe}, 16'd0);
    end
    sclk = 1'b0;
    wait_clk(6);
    frame(6'h03, 2'b00, 4'h0, 0, 16, r);
    chk("R10 idle no echo change", {8'd0, r[15:8]}, {8'd0, 6'h30, 2'b11});
    chk("R10 idle no reg change", {8'd0, r[7:0]}, {8'd0, par(4'h6), 4'h6});
    chk("R10 idle no err", {15'd0, err}, 16'd0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_read();
    t_parity();
    t_rw_split();
    t_length();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule